// File: doc/BRIEF.md
# Reset Cause Recorder and Boot Configuration Latch

This block sequences the chip-level reset output and keeps a record of what caused the most recent reset. Hardware reset requests come from power-on, the external reset pin and the watchdog. Software can raise two more requests, a system reset and an external reset, by writing the control register. Every request enters one sequencing path. The path holds the reset output asserted and then releases it a fixed number of cycles after the last active request.

When the reset output releases, the block samples the weak-pull select pin. It also samples the boot and clock-generator configuration pins, but only if the configuration enable pin is high at that moment. If the enable pin is low, built-in defaults are loaded instead. A status register shows the cause bits, the latched boot and weak-pull values, and a sticky reset-pin glitch flag that software clears by writing 1. Reads are combinational on the address, and writes take effect at the clock edge.

Top module: `rst_cause_latch`

## Requirements
- R1: While and right after `rst_n` is low, `rst_out_o` is 1, the status cause bits equal 5'b00001 (power-on only), the glitch flag is 0, `boot_cfg_o` is BOOT_DEF (2'b00), `pll_cfg_o` is PLL_DEF (2'b10) and `wkp_cfg_o` is 0.
- R2: A request sampled at a clock edge makes `rst_out_o` 1 after that edge. `rst_out_o` falls at the HOLD_CYCLES-th edge (16 by default) that follows the last edge with any request.
- R3: Cause bits are status[4:0] = {sw external, sw system, watchdog, pin, power-on}. A request that arrives while `rst_out_o` is 0 replaces all cause bits with the requests of that cycle, so simultaneous requests all set together. Requests that arrive while `rst_out_o` is 1 are ORed in.
- R4: A software external request that arrives alone while `rst_out_o` is 0 sets status[4] and keeps every other cause bit.
- R5: At the release edge of `rst_out_o` with `cfg_en_i` high, `boot_cfg_o` and `pll_cfg_o` take the pin values. They change at no other edge.
- R6: At the release edge with `cfg_en_i` low, `boot_cfg_o` becomes 2'b00 and `pll_cfg_o` becomes 2'b10. `wkp_cfg_o` takes `wkp_pin_i` at every release edge.
- R7: status[17:16] shows `boot_cfg_o` and status[20] shows `wkp_cfg_o`.
- R8: status[8] is the glitch flag. It is set by a `glitch_i` pulse and cleared by writing 1 to bit 8 at offset 0x0C. Writing 0 to that bit leaves it unchanged, and a set in the same cycle as a clear wins.
- R9: A write to offset 0x0C changes no cause bit and no configuration bit.
- R10: Writing 1 to bit 0 at offset 0x10 raises a one-cycle software system request, and writing 1 to bit 1 raises a software external request. Either request reaches the sequencer one cycle after the write. Offset 0x10 always reads 0.
- R11: `bus_rdata_o` is a combinational function of `bus_addr_i`. Every address other than 0x0C reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; behaves as a power-on request |
| req_por_i | input | 1 | Power-on reset request |
| req_pin_i | input | 1 | External reset pin request |
| req_wdog_i | input | 1 | Watchdog reset request |
| glitch_i | input | 1 | Reset pin glitch detect pulse |
| cfg_en_i | input | 1 | Enables sampling of the boot and clock-generator pins |
| boot_pins_i | input | 2 | Boot configuration pins |
| pll_pins_i | input | 2 | Clock-generator configuration pins |
| wkp_pin_i | input | 1 | Weak-pull direction select pin |
| bus_sel_i | input | 1 | Bus access select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| rst_out_o | output | 1 | Chip reset output, active high |
| boot_cfg_o | output | 2 | Latched boot configuration |
| pll_cfg_o | output | 2 | Latched clock-generator configuration |
| wkp_cfg_o | output | 1 | Latched weak-pull select |

## Verification
The bench builds the block with its default parameters: a 16-cycle hold, an 8-bit address and the defaults 2'b00 / 2'b10. The short hold means thousands of random cycles walk through many complete assert-and-release sequences. These sequences include requests that arrive in the middle of a hold, back-to-back software requests and releases with the enable pin in either state. The default clock-generator value differs from most pin patterns, so a release that samples when it should not shows up on the outputs.

// File: rtl/rcl_pkg.sv
package rcl_pkg;
    localparam int DATA_W     = 32;
    localparam int NSRC       = 5;
    localparam int SRC_POR    = 0;
    localparam int SRC_PIN    = 1;
    localparam int SRC_WDOG   = 2;
    localparam int SRC_SWSYS  = 3;
    localparam int SRC_SWEXT  = 4;
    localparam int GLITCH_BIT = 8;
    localparam int BOOT_LSB   = 16;
    localparam int WKP_BIT    = 20;
    localparam int CTRL_SYS   = 0;
    localparam int CTRL_EXT   = 1;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        logic [1:0] boot;
        logic [1:0] pll;
        logic       wkp;
    } cfg_t;
endpackage

// File: rtl/rcl_seq.sv
module rcl_seq
    import rcl_pkg::*;
#(
    parameter int HOLD_CYCLES = 16,
    parameter int CNT_W       = $clog2(HOLD_CYCLES + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t req_i,
    output logic     rst_out_o,
    output logic     release_o,
    output src_vec_t src_o
);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYCLES);
    localparam src_vec_t         EXT_ONLY = src_vec_t'(1 << SRC_SWEXT);
    localparam src_vec_t         POR_ONLY = src_vec_t'(1 << SRC_POR);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        src_vec_t         src;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       rel_d;

    always_comb begin
        st_d  = st_q;
        rel_d = 1'b0;
        if (|req_i) begin
            if (!st_q.active) begin
                // a new reset event; a lone software external request is additive
                st_d.src = (req_i == EXT_ONLY) ? (st_q.src | req_i) : req_i;
            end else begin
                st_d.src = st_q.src | req_i;
            end
            st_d.active = 1'b1;
            st_d.cnt    = HOLD_LD;
        end else if (st_q.active) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
                rel_d       = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= 1'b1;
            st_q.cnt    <= HOLD_LD;
            st_q.src    <= POR_ONLY;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_out_o = st_q.active;
    assign release_o = rel_d;
    assign src_o     = st_q.src;
endmodule

// File: rtl/rcl_cfg.sv
module rcl_cfg
    import rcl_pkg::*;
#(
    parameter logic [1:0] PLL_DEF  = 2'b10,
    parameter logic [1:0] BOOT_DEF = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       release_i,
    input  logic       cfg_en_i,
    input  logic [1:0] boot_i,
    input  logic [1:0] pll_i,
    input  logic       wkp_i,
    output cfg_t       cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (release_i) begin
            cfg_d.wkp  = wkp_i;
            cfg_d.boot = cfg_en_i ? boot_i : BOOT_DEF;
            cfg_d.pll  = cfg_en_i ? pll_i  : PLL_DEF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.boot <= BOOT_DEF;
            cfg_q.pll  <= PLL_DEF;
            cfg_q.wkp  <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/rcl_bus.sv
module rcl_bus
    import rcl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int OFS_STATUS  = 'h0C,
    parameter int OFS_CTRL    = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              glitch_i,
    input  src_vec_t          src_i,
    input  cfg_t              cfg_i,
    output logic              sw_sys_o,
    output logic              sw_ext_o,
    output logic              gflag_o
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

    typedef struct packed {
        logic gflag;
        logic sw_sys;
        logic sw_ext;
    } bus_state_t;

    bus_state_t bs_d, bs_q;
    logic       wr_stat, wr_ctrl;
    logic       unused_wdata;

    assign wr_stat      = sel_i && wr_i && (addr_i == A_STAT);
    assign wr_ctrl      = sel_i && wr_i && (addr_i == A_CTRL);
    assign unused_wdata = ^wdata_i;

    always_comb begin
        bs_d        = bs_q;
        bs_d.sw_sys = wr_ctrl && wdata_i[CTRL_SYS];
        bs_d.sw_ext = wr_ctrl && wdata_i[CTRL_EXT];
        if (glitch_i) begin
            bs_d.gflag = 1'b1;
        end else if (wr_stat && wdata_i[GLITCH_BIT]) begin
            bs_d.gflag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bs_q <= '0;
        end else begin
            bs_q <= bs_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_STAT) begin
            rdata_o[NSRC-1:0]            = src_i;
            rdata_o[GLITCH_BIT]          = bs_q.gflag;
            rdata_o[BOOT_LSB+1:BOOT_LSB] = cfg_i.boot;
            rdata_o[WKP_BIT]             = cfg_i.wkp;
        end
    end

    assign sw_sys_o = bs_q.sw_sys;
    assign sw_ext_o = bs_q.sw_ext;
    assign gflag_o  = bs_q.gflag;
endmodule

// File: rtl/rst_cause_latch.sv
module rst_cause_latch
    import rcl_pkg::*;
#(
    parameter int         HOLD_CYCLES = 16,
    parameter int         ADDR_W      = 8,
    parameter logic [1:0] PLL_DEF     = 2'b10,
    parameter logic [1:0] BOOT_DEF    = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_por_i,
    input  logic              req_pin_i,
    input  logic              req_wdog_i,
    input  logic              glitch_i,
    input  logic              cfg_en_i,
    input  logic [1:0]        boot_pins_i,
    input  logic [1:0]        pll_pins_i,
    input  logic              wkp_pin_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              rst_out_o,
    output logic [1:0]        boot_cfg_o,
    output logic [1:0]        pll_cfg_o,
    output logic              wkp_cfg_o
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    src_vec_t req_vec, src_vec;
    cfg_t     cfg;
    logic     sw_sys, sw_ext, release_s, gflag;

    always_comb begin
        req_vec            = '0;
        req_vec[SRC_POR]   = req_por_i;
        req_vec[SRC_PIN]   = req_pin_i;
        req_vec[SRC_WDOG]  = req_wdog_i;
        req_vec[SRC_SWSYS] = sw_sys;
        req_vec[SRC_SWEXT] = sw_ext;
    end

    rcl_seq #(.HOLD_CYCLES(HOLD_CYCLES), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req_vec),
        .rst_out_o(rst_out_o), .release_o(release_s), .src_o(src_vec)
    );

    rcl_cfg #(.PLL_DEF(PLL_DEF), .BOOT_DEF(BOOT_DEF)) u_cfg (
        .clk(clk), .rst_n(rst_n), .release_i(release_s), .cfg_en_i(cfg_en_i),
        .boot_i(boot_pins_i), .pll_i(pll_pins_i), .wkp_i(wkp_pin_i), .cfg_o(cfg)
    );

    rcl_bus #(.ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .sel_i(bus_sel_i), .wr_i(bus_wr_i),
        .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
        .glitch_i(glitch_i), .src_i(src_vec), .cfg_i(cfg),
        .sw_sys_o(sw_sys), .sw_ext_o(sw_ext), .gflag_o(gflag)
    );

    assign boot_cfg_o = cfg.boot;
    assign pll_cfg_o  = cfg.pll;
    assign wkp_cfg_o  = cfg.wkp;
endmodule

// File: rtl/rcl_checker.sv
module rcl_checker
    import rcl_pkg::*;
#(
    parameter int         HOLD_CYCLES = 16,
    parameter int         ADDR_W      = 8,
    parameter logic [1:0] PLL_DEF     = 2'b10,
    parameter logic [1:0] BOOT_DEF    = 2'b00
) (
    input logic              clk,
    input logic              rst_n,
    input src_vec_t          req_vec,
    input src_vec_t          src_vec,
    input logic              rst_out,
    input logic              cfg_en,
    input logic [1:0]        boot,
    input logic [1:0]        pll,
    input logic              wkp,
    input logic              glitch,
    input logic              gflag,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata
);
    localparam src_vec_t EXT_ONLY = src_vec_t'(1 << SRC_SWEXT);
    localparam int       QW       = $clog2(HOLD_CYCLES + 2);

    logic [QW-1:0] quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= '0;
        end else if (|req_vec) begin
            quiet_q <= '0;
        end else if (quiet_q <= QW'(HOLD_CYCLES)) begin
            quiet_q <= quiet_q + QW'(1);
        end
    end

    p_req_asserts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_vec) |=> rst_out);

    p_hold_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> (quiet_q == QW'(HOLD_CYCLES)));

    p_new_event_replaces_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_out && (|req_vec) && req_vec != EXT_ONLY) |=> (src_vec == $past(req_vec)));

    p_swext_additive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_out && req_vec == EXT_ONLY) |=> (src_vec == ($past(src_vec) | EXT_ONLY)));

    p_cfg_only_at_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({boot, pll, wkp}) |-> $fell(rst_out));

    p_defaults_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rst_out) && !$past(cfg_en)) |-> (boot == BOOT_DEF && pll == PLL_DEF));

    p_glitch_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        glitch |=> gflag);

    p_other_addr_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != ADDR_W'('h0C)) |-> (rdata == 32'd0));
endmodule

bind rst_cause_latch rcl_checker #(
    .HOLD_CYCLES(HOLD_CYCLES), .ADDR_W(ADDR_W), .PLL_DEF(PLL_DEF), .BOOT_DEF(BOOT_DEF)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .src_vec(src_vec),
    .rst_out(rst_out_o), .cfg_en(cfg_en_i), .boot(boot_cfg_o), .pll(pll_cfg_o),
    .wkp(wkp_cfg_o), .glitch(glitch_i), .gflag(gflag), .addr(bus_addr_i),
    .rdata(bus_rdata_o)
);

// File: tb/rst_cause_latch_tb_top.sv
module rst_cause_latch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 16;
    localparam int RAND_CYC   = 4000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        por, pin, wdog, glitch, cfg_en, wkp, sel, wr;
    logic [1:0]  bootp, pllp;
    logic [7:0]  addr;
    logic [31:0] wdata, rdata;
    logic        rst_out, wkp_o;
    logic [1:0]  boot_o, pll_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // bench model state
    logic       m_rst, m_flag, m_sys, m_ext, m_wkp;
    logic [4:0] m_src;
    logic [1:0] m_boot, m_pll;
    int         m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_cause_latch dut_i (
        .clk(clk), .rst_n(rst_n), .req_por_i(por), .req_pin_i(pin), .req_wdog_i(wdog),
        .glitch_i(glitch), .cfg_en_i(cfg_en), .boot_pins_i(bootp), .pll_pins_i(pllp),
        .wkp_pin_i(wkp), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .rst_out_o(rst_out),
        .boot_cfg_o(boot_o), .pll_cfg_o(pll_o), .wkp_cfg_o(wkp_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (a == 8'h0C)
            return 32'(m_src) | (32'(m_flag) << 8) | (32'(m_boot) << 16) | (32'(m_wkp) << 20);
        return 32'd0;
    endfunction

    task automatic model_update();
        logic [4:0] req;
        logic n_sys, n_ext;
        req   = {m_ext, m_sys, wdog, pin, por};
        n_sys = sel && wr && addr == 8'h10 && wdata[0];
        n_ext = sel && wr && addr == 8'h10 && wdata[1];
        if (glitch) m_flag = 1'b1;
        else if (sel && wr && addr == 8'h0C && wdata[8]) m_flag = 1'b0;
        if (req != 5'd0) begin
            if (!m_rst) m_src = (req == 5'b10000) ? (m_src | req) : req;
            else        m_src = m_src | req;
            m_rst = 1'b1;
            m_cnt = HOLD;
        end else if (m_rst) begin
            if (m_cnt <= 1) begin
                m_rst  = 1'b0;
                m_cnt  = 0;
                m_wkp  = wkp;
                m_boot = cfg_en ? bootp : 2'b00;
                m_pll  = cfg_en ? pllp  : 2'b10;
            end else begin
                m_cnt--;
            end
        end
        m_sys = n_sys;
        m_ext = n_ext;
    endtask

    // inputs are driven just after a falling edge; this checks, clocks, and returns at the next falling edge
    task automatic tick();
        #1;
        check("R2 rst_out", 32'(rst_out), 32'(m_rst));
        check("R5 boot/pll", {28'd0, boot_o, pll_o}, {28'd0, m_boot, m_pll});
        check("R6 wkp", 32'(wkp_o), 32'(m_wkp));
        if (sel && !wr) begin
            if (addr == 8'h0C)      check("R3 status read", rdata, model_read(addr));
            else if (addr == 8'h10) check("R10 control read", rdata, 32'd0);
            else                    check("R11 unmapped read", rdata, 32'd0);
        end
        @(posedge clk);
        model_update();
        #1;
        por = 0; pin = 0; wdog = 0; glitch = 0; sel = 0; wr = 0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        sel = 1; wr = 1; addr = a; wdata = d;
        tick();
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        sel = 1; wr = 0; addr = a;
        #1;
        d = rdata;
        tick();
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: got %0d cycles expected completion", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [31:0] rv;
        int unsigned seed;
        seed = $urandom(32'h5EED_1234);
        rst_n = 0; por = 0; pin = 0; wdog = 0; glitch = 0; sel = 0; wr = 0;
        addr = 8'h0C; wdata = 0; cfg_en = 0; bootp = 2'b11; pllp = 2'b01; wkp = 1;
        m_rst = 1; m_cnt = HOLD; m_src = 5'b00001; m_flag = 0; m_sys = 0; m_ext = 0;
        m_boot = 2'b00; m_pll = 2'b10; m_wkp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        #1;
        check("R1 rst_out", 32'(rst_out), 32'd1);
        check("R1 status", rdata, 32'h0000_0001);
        check("R1 cfg", {27'd0, boot_o, pll_o, wkp_o}, {27'd0, 2'b00, 2'b10, 1'b0});

        // R6: release with sampling disabled
        idle(HOLD + 4);
        check("R6 default boot", 32'(boot_o), 32'd0);
        check("R6 default pll", 32'(pll_o), 32'd2);
        check("R6 wkp sampled", 32'(wkp_o), 32'd1);

        // R5, R3, R7: pin request with sampling enabled
        cfg_en = 1; bootp = 2'b01; pllp = 2'b11;
        pin = 1; tick();
        idle(HOLD + 2);
        check("R5 boot sampled", 32'(boot_o), 32'd1);
        check("R5 pll sampled", 32'(pll_o), 32'd3);
        bus_read(8'h0C, rv);
        check("R3 pin replaces por", {27'd0, rv[4:0]}, 32'b00010);
        check("R7 boot field", 32'(rv[17:16]), 32'd1);
        check("R7 wkp field", 32'(rv[20]), 32'd1);

        // R4: software external alone is additive
        bus_write(8'h10, 32'h2);
        idle(HOLD + 2);
        bus_read(8'h0C, rv);
        check("R4 swext additive", {27'd0, rv[4:0]}, 32'b10010);

        // R8: glitch flag write-1-to-clear
        glitch = 1; tick();
        bus_read(8'h0C, rv);
        check("R8 flag set", 32'(rv[8]), 32'd1);
        bus_write(8'h0C, 32'h0);
        bus_read(8'h0C, rv);
        check("R8 write 0 keeps", 32'(rv[8]), 32'd1);
        bus_write(8'h0C, 32'h100);
        bus_read(8'h0C, rv);
        check("R8 write 1 clears", 32'(rv[8]), 32'd0);
        glitch = 1; bus_write(8'h0C, 32'h100);
        bus_read(8'h0C, rv);
        check("R8 set wins", 32'(rv[8]), 32'd1);

        // R9: status writes leave cause and config bits
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_read(8'h0C, rv);
        check("R9 read-only fields", rv, 32'h0011_0012);

        // R3: simultaneous requests
        por = 1; wdog = 1; tick();
        idle(HOLD + 2);
        bus_read(8'h0C, rv);
        check("R3 simultaneous", {27'd0, rv[4:0]}, 32'b00101);

        // R10: both software bits, control reads zero
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, rv);
        check("R10 ctrl reads 0", rv, 32'd0);
        check("R10 request reached", 32'(rst_out), 32'd1);
        idle(HOLD + 2);
        bus_read(8'h0C, rv);
        check("R10 both sw causes", {27'd0, rv[4:0]}, 32'b11000);
        bus_read(8'h14, rv);
        check("R11 unmapped", rv, 32'd0);

        // constrained random phase
        for (int c = 0; c < RAND_CYC; c++) begin
            int unsigned k;
            por    = ($urandom % 97) == 0;
            pin    = ($urandom % 61) == 0;
            wdog   = ($urandom % 53) == 0;
            glitch = ($urandom % 17) == 0;
            cfg_en = $urandom % 2;
            bootp  = 2'($urandom);
            pllp   = 2'($urandom);
            wkp    = 1'($urandom);
            sel    = $urandom % 2;
            wr     = ($urandom % 3) == 0;
            k      = $urandom % 8;
            addr   = (k < 3) ? 8'h0C : (k == 3) ? 8'h10 : 8'($urandom);
            wdata  = $urandom;
            if (addr == 8'h10 && wr && ($urandom % 4) != 0) wdata = 32'd0;
            tick();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule